// File: doc/BRIEF.md
# System Interrupt Router

This block collects 32 device interrupt lines into one system pending register, filters them through a disable mask, and steers what remains to a single selected processor. Each source bit is translated to a processor interrupt level through a fixed bit-to-level table. The table is a parameter; by default source j maps to level (j mod 15) + 1. The OR of all levels that are reached forms a 16-bit level vector. That vector is driven on the output lane of the selected processor, and every other lane is held at zero.

Software reaches the block through a small word-addressed register port. It can read the pending and disable state. It can re-enable sources by writing ones to clear disable bits. It can disable sources by writing ones, which also discards their pending state. It can also choose the target processor. A hardwired set of bits in the disable register can never be written. Bit 31 of the disable register acts as a global switch: while it is set, no source reaches any processor.

Top module: `irq_router`

## Requirements
- R1: After reset the disable register reads 0x4fb2007f, the pending register reads 0, the target index is 0 and every level output lane is 0.
- R2: A rising source line n sets pending bit n and a falling one clears it, visible at read offset 0 (address bits [4:2] = 0) after the next clock edge; bit 31 always reads as 0 at that offset.
- R3: A read at word offset 1 returns the disable register.
- R4: A write at word offset 2 clears every disable bit that is set in both the written value and the writable mask 0xb04dff80.
- R5: A write at word offset 3 sets the disable bits selected by value AND 0xb04dff80 and clears the same pending bits; a cleared pending bit stays clear while its source is held high, until the source falls and rises again.
- R6: A write at word offset 4 sets the target index to the written value's bits [1:0].
- R7: Each pending, non-disabled source j sets bit LEVEL_MAP[j] of the target lane (default (j mod 15)+1), with the lane registered one clock after the pending, disable or target state changes.
- R8: While disable bit 31 is set every level lane is 0.
- R9: Lanes of processors other than the target are 0, so at most one lane is non-zero.
- R10: Disable bits inside 0x4fb2007f stay set at all times after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIrq | input | 32 | Device interrupt lines, one per source |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Byte address; bits [4:2] pick the word |
| wrData | input | 32 | Register write value |
| rdData | output | 32 | Read value for the word at regAddr |
| cpuLevels | output | NUM_CPU*16 | Level lanes, 16 bits per processor, lane i at [16i+15:16i] |

## Verification
The assertions assume at most one register write per clock. They also assume that the write strobe is inactive during a read, because read checks sample the port only when the strobe is low. Several assertions look one cycle back, so they treat the decoded strobe and masked value of the previous cycle as what the registers took in. The bench meets these assumptions by changing every input only on the falling clock edge. It holds each write for exactly one rising edge, keeps source patterns stable across two rising edges before it compares the outputs, and reads only while the write strobe is low.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int SRC_N  = 32;
  localparam int LVL_N  = 16;
  localparam int LVL_W  = 4;
  localparam int MASTER = 31;
  localparam logic [SRC_N-1:0] FIXED_BITS = 32'h4fb2007f;
  localparam logic [SRC_N-1:0] WR_MASK    = ~FIXED_BITS;

  typedef struct packed {
    logic             enStb;   // clear disable bits
    logic             disStb;  // set disable bits, drop pending
    logic             tgtStb;  // load target index
    logic [SRC_N-1:0] bits;    // masked value (raw for target)
  } ctlStrobe_t;

  function automatic logic [SRC_N*LVL_W-1:0] defaultMap();
    logic [SRC_N*LVL_W-1:0] m;
    for (int j = 0; j < SRC_N; j++) m[j*LVL_W +: LVL_W] = LVL_W'((j % 15) + 1);
    return m;
  endfunction
endpackage

// File: rtl/irq_router_ctl.sv
module irq_router_ctl
  import irq_router_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [4:0]       regAddr,
  input  logic [SRC_N-1:0] wrData,
  input  logic [SRC_N-1:0] pendQ,
  input  logic [SRC_N-1:0] disQ,
  output ctlStrobe_t       strb,
  output logic [SRC_N-1:0] rdData
);
  logic [2:0] word;
  logic       unusedAddr;
  assign word       = regAddr[4:2];
  assign unusedAddr = ^regAddr[1:0];

  always_comb begin
    strb.enStb  = wrEn && (word == 3'd2);
    strb.disStb = wrEn && (word == 3'd3);
    strb.tgtStb = wrEn && (word == 3'd4);
    strb.bits   = strb.tgtStb ? wrData : (wrData & WR_MASK);
  end

  always_comb begin
    case (word)
      3'd0:    rdData = pendQ & ~(SRC_N'(1) << MASTER);
      3'd1:    rdData = disQ;
      default: rdData = '0;
    endcase
  end

  // R2: the top pending bit never shows on the read port
  a_r2_top_bit_hidden: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && word == 3'd0) |-> !rdData[MASTER]);

  // R3: offset 1 mirrors the disable register
  a_r3_disable_visible: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && word == 3'd1) |-> (rdData == disQ));
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter logic [SRC_N*LVL_W-1:0] LEVEL_MAP = defaultMap()
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [SRC_N-1:0]         srcIrq,
  input  ctlStrobe_t               strb,
  output logic [SRC_N-1:0]         pendQ,
  output logic [SRC_N-1:0]         disQ,
  output logic [NUM_CPU*LVL_N-1:0] cpuLevels
);
  localparam int TGT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  logic [SRC_N-1:0] srcPrev, rise, fall, dropMask, enab;
  logic [TGT_W-1:0] tgtQ;
  logic [LVL_N-1:0] levelVec;
  logic [LVL_N-1:0] contrib [SRC_N];
  logic [NUM_CPU-1:0] laneBusy;

  assign rise     = srcIrq & ~srcPrev;
  assign fall     = ~srcIrq & srcPrev;
  assign dropMask = strb.disStb ? strb.bits : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPrev <= '0;
      pendQ   <= '0;
      disQ    <= FIXED_BITS;
      tgtQ    <= '0;
    end else begin
      srcPrev <= srcIrq;
      pendQ   <= (pendQ | rise) & ~fall & ~dropMask;
      if (strb.enStb)       disQ <= disQ & ~strb.bits;
      else if (strb.disStb) disQ <= disQ | strb.bits;
      if (strb.tgtStb)      tgtQ <= strb.bits[TGT_W-1:0];
    end
  end

  assign enab = pendQ & ~disQ;

  for (genvar j = 0; j < SRC_N; j++) begin : g_map
    assign contrib[j] = enab[j] ? (LVL_N'(1) << LEVEL_MAP[j*LVL_W +: LVL_W]) : '0;
  end

  always_comb begin
    levelVec = '0;
    for (int j = 0; j < SRC_N; j++) levelVec |= contrib[j];
    if (disQ[MASTER]) levelVec = '0;
  end

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN) cpuLevels[i*LVL_N +: LVL_N] <= '0;
      else       cpuLevels[i*LVL_N +: LVL_N] <= (tgtQ == TGT_W'(i)) ? levelVec : '0;
    end
    assign laneBusy[i] = |cpuLevels[i*LVL_N +: LVL_N];

    // R9: a lane that is not the target carries nothing next cycle
    a_r9_nontarget_zero: assert property (@(posedge clk) disable iff (!rstN)
      (tgtQ != TGT_W'(i)) |=> (cpuLevels[i*LVL_N +: LVL_N] == '0));
  end

  // R9: at most one lane active
  a_r9_single_lane: assert property (@(posedge clk) disable iff (!rstN) $onehot0(laneBusy));

  // R8: global switch blocks every lane
  a_r8_master_blocks: assert property (@(posedge clk) disable iff (!rstN)
    disQ[MASTER] |=> (cpuLevels == '0));

  // R5: disable write leaves no selected pending bit
  a_r5_disable_drops_pending: assert property (@(posedge clk) disable iff (!rstN)
    strb.disStb |=> ((pendQ & $past(strb.bits)) == '0));

  // R4: enable write clears the selected disable bits
  a_r4_enable_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.enStb |=> ((disQ & $past(strb.bits)) == '0));

  // R10: hardwired disable bits never drop
  a_r10_fixed_bits_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((disQ & FIXED_BITS) == FIXED_BITS));
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter logic [SRC_N*LVL_W-1:0] LEVEL_MAP = defaultMap()
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [31:0]              srcIrq,
  input  logic                     wrEn,
  input  logic [4:0]               regAddr,
  input  logic [31:0]              wrData,
  output logic [31:0]              rdData,
  output logic [NUM_CPU*16-1:0]    cpuLevels
);
  ctlStrobe_t       strb;
  logic [SRC_N-1:0] pendQ, disQ;

  irq_router_ctl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .pendQ(pendQ), .disQ(disQ), .strb(strb), .rdData(rdData)
  );

  irq_router_dp #(.NUM_CPU(NUM_CPU), .LEVEL_MAP(LEVEL_MAP)) u_dp (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .strb(strb),
    .pendQ(pendQ), .disQ(disQ), .cpuLevels(cpuLevels)
  );
endmodule

// File: tb/irq_router_test.sv
module irq_router_test;
  localparam int NCPU = 4;
  localparam logic [31:0] FIXED = 32'h4fb2007f;
  localparam logic [31:0] WMASK = 32'hb04dff80;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [31:0] srcIrq = '0, wrData = '0, rdData;
  logic [4:0]  regAddr = '0;
  logic [NCPU*16-1:0] cpuLevels;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] mPend, mDis, mSrc;
  logic [1:0]  mTgt;

  localparam logic [31:0] srcTab [8] = '{
    32'h0000_0080, 32'h0000_8000, 32'h0001_0000, 32'h0040_0000,
    32'h1000_0000, 32'h0000_0001, 32'h8000_0000, 32'h30C5_FF81 };

  irq_router #(.NUM_CPU(NCPU)) uut (.*);

  always #5 clk = ~clk;

  function automatic logic [15:0] expLane(int cpu);
    logic [15:0] v = '0;
    logic [31:0] en = mPend & ~mDis;
    if (cpu != int'(mTgt) || mDis[31]) return '0;
    for (int j = 0; j < 32; j++) if (en[j]) v |= 16'(1) << ((j % 15) + 1);
    return v;
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic readWord(int w, output logic [31:0] v);
    regAddr = 5'(w << 2);
    #1 v = rdData;
  endtask

  task automatic checkAll(string tag);
    logic [31:0] v;
    readWord(0, v); cmp({tag, " pending (R2)"}, v, mPend & 32'h7fff_ffff);
    readWord(1, v); cmp({tag, " disable (R3)"}, v, mDis);
    for (int i = 0; i < NCPU; i++)
      cmp($sformatf("%s lane%0d (R7/R9)", tag, i), 32'(cpuLevels[i*16 +: 16]), 32'(expLane(i)));
  endtask

  task automatic setSrc(logic [31:0] v);
    srcIrq = v;
    mPend = (mPend | (v & ~mSrc)) & ~(mSrc & ~v);
    mSrc = v;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic wr(int w, logic [31:0] d);
    regAddr = 5'(w << 2); wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0;
    if (w == 2) mDis &= ~(d & WMASK);
    if (w == 3) begin mDis |= d & WMASK; mPend &= ~(d & WMASK); end
    if (w == 4) mTgt = d[1:0];
    @(negedge clk);
  endtask

  initial begin
    mPend = '0; mDis = FIXED; mSrc = '0; mTgt = '0;
    repeat (3) @(negedge clk);
    checkAll("R1 in reset");
    rstN = 1;
    @(negedge clk);
    checkAll("R1 after reset");

    // R2 / R7: vector walk with default routing to lane 0
    for (int k = 0; k < 8; k++) begin
      setSrc(srcTab[k]);
      checkAll($sformatf("R7 vec%0d", k));
    end
    setSrc('0);
    checkAll("R2 all low");

    // R5: disable drops pending, stays dropped while source held
    setSrc(32'h0000_0100);
    checkAll("R7 bit8");
    wr(3, 32'h0000_0100);
    checkAll("R5 disabled");
    wr(2, 32'h0000_0100);
    checkAll("R5 re-enabled no pending (R4)");
    setSrc('0); setSrc(32'h0000_0100);
    checkAll("R5 retrigger");

    // R6 / R9: retarget
    wr(4, 32'h0000_0002);
    checkAll("R6 target2");
    wr(4, 32'hffff_ff07);
    checkAll("R6 target3");

    // R8: global switch
    wr(3, 32'h8000_0000);
    checkAll("R8 master off");
    setSrc(32'h0040_8100);
    checkAll("R8 master off new src");
    wr(2, 32'h8000_0000);
    checkAll("R8 master on (R4)");

    // R10: fixed bits unaffected by writes
    wr(2, 32'hffff_ffff);
    checkAll("R10 enable all");
    wr(3, 32'hffff_ffff);
    checkAll("R10 disable all");
    wr(2, 32'hffff_ffff);
    setSrc('0); setSrc(32'h0000_0001);
    checkAll("R10 fixed source blocked");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule